// File: doc/BRIEF.md
# Secure-Aware Exception Entry Controller

This block decides, once per clock, whether a pipelined processor with a secure and a non-secure world takes an exception, and if so where it goes. It looks at all pending exception requests together. These are the reset request, undefined instruction, secure monitor call, breakpoint, prefetch abort, data abort (optionally flagged as external), IRQ and FIQ. It combines them with the current world, the privilege mode, the interrupt masks, three routing bits and the state of the execute-stage instruction, and picks one winner.

For the winner it produces a one-cycle take strobe, the target mode and world, the vector fetch address, the link value and the mask updates. The vector address is built from one of three programmable bases: non-secure, secure or monitor. A high-vector enable replaces the non-secure and secure bases with a fixed high base. A breakpoint taken while halting debug is enabled does not enter an exception. It raises a debug-entry request instead.

All outputs are registered. They reflect the inputs sampled at the previous rising edge and are all zero when nothing is taken.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is 0.
- R2: A decision is made from the inputs sampled at a rising edge and appears on the outputs right after that edge. `take_o` and `dbg_req_o` are high for exactly the cycles whose sampled inputs produce them.
- R3: When several requests are eligible in one cycle, only one is served. The order is: reset request, data abort, FIQ, IRQ, prefetch abort, breakpoint, undefined instruction, monitor call.
- R4: An IRQ is not eligible while `irq_masked_i` is 1, and an FIQ is not eligible while `fiq_masked_i` is 1.
- R5: Undefined instruction, monitor call, breakpoint and prefetch abort are eligible only when `ex_valid_i` is 1. A squashed breakpoint produces neither a take nor a debug request.
- R6: An eligible winning breakpoint with `halt_dbg_i` = 1 gives `dbg_req_o` = 1 and `take_o` = 0. With `halt_dbg_i` = 0 it is taken like a prefetch abort: abort mode, offset 0x0C.
- R7: A monitor call from user mode (`cur_mode_i` = 0) is taken as an undefined instruction: mode 5, offset 0x04. From any other mode it enters monitor mode (6) with offset 0x08.
- R8: Mode encoding: 0 user, 1 FIQ, 2 IRQ, 3 supervisor, 4 abort, 5 undefined, 6 monitor. The reset request targets supervisor mode. `route_i[0]` sends IRQ, `route_i[1]` sends FIQ and `route_i[2]` sends a data abort with `dabt_ext_i` = 1 into monitor mode in place of modes 2, 1 and 4.
- R9: The target world is secure for monitor mode and for the reset request. Otherwise it is the current world. The base is `base_mon_i` for monitor mode, `base_s_i` for the secure world and `base_ns_i` for the non-secure world.
- R10: With `hivec_i` = 1, every non-monitor target uses base 0xFFFF0000. The monitor base is never replaced.
- R11: Vector = base + offset. Offsets: reset 0x00, undefined 0x04, monitor call 0x08, prefetch abort/breakpoint 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R12: The link value is `ex_pc_i`+4 for undefined, monitor call, prefetch abort, breakpoint, IRQ and FIQ; `ex_pc_i`+8 for a data abort; 0 for the reset request.
- R13: Every take sets `set_irq_mask_o`. `set_fiq_mask_o` is set only when an FIQ is taken or monitor mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_exc_i | input | 1 | Reset exception request |
| undef_i | input | 1 | Undefined instruction in execute |
| smc_i | input | 1 | Secure monitor call in execute |
| bkpt_i | input | 1 | Breakpoint instruction in execute |
| pabt_i | input | 1 | Prefetch abort on execute instruction |
| dabt_i | input | 1 | Data abort request |
| dabt_ext_i | input | 1 | Data abort is external |
| irq_i | input | 1 | IRQ request |
| fiq_i | input | 1 | FIQ request |
| cur_secure_i | input | 1 | Current world is secure |
| cur_mode_i | input | 3 | Current mode |
| irq_masked_i | input | 1 | IRQ currently masked |
| fiq_masked_i | input | 1 | FIQ currently masked |
| route_i | input | 3 | Monitor routing: IRQ, FIQ, external abort |
| hivec_i | input | 1 | High-vector enable |
| base_ns_i | input | 32 | Non-secure vector base |
| base_s_i | input | 32 | Secure vector base |
| base_mon_i | input | 32 | Monitor vector base |
| halt_dbg_i | input | 1 | Halting debug enabled |
| ex_valid_i | input | 1 | Execute instruction valid, not squashed |
| ex_pc_i | input | 32 | Address of execute instruction |
| take_o | output | 1 | Exception taken |
| tgt_mode_o | output | 3 | Target mode |
| tgt_secure_o | output | 1 | Target world is secure |
| vec_o | output | 32 | Vector fetch address |
| link_o | output | 32 | Link value |
| set_irq_mask_o | output | 1 | Set IRQ mask |
| set_fiq_mask_o | output | 1 | Set FIQ mask |
| dbg_req_o | output | 1 | Debug-state entry request |

## Verification
Two functions often meet in the same cycle: a breakpoint under halting debug and a higher-priority asynchronous event, such as an unmasked FIQ or a data abort. The event must win and be taken, and no debug request may appear. Another common collision is a monitor call that competes with a routed IRQ. The bench provokes these by sweeping every combination of the nine request inputs against configurations varied in lockstep: world, mode, masks, routing, high vectors, halting debug and execute validity. It judges every output field against a model that redoes the priority, routing and address arithmetic its own way.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int AW   = 32;
  localparam int NREQ = 8;

  typedef enum logic [2:0] {
    M_USR = 3'd0, M_FIQ = 3'd1, M_IRQ = 3'd2, M_SVC = 3'd3,
    M_ABT = 3'd4, M_UND = 3'd5, M_MON = 3'd6, M_SYS = 3'd7
  } mode_e;

  typedef enum logic [3:0] {
    C_NONE, C_RST, C_DABT, C_FIQ, C_IRQ, C_PABT, C_BKPT, C_UND, C_SMC
  } cause_e;

  // request slot index equals priority rank (0 = highest)
  function automatic cause_e slot_cause(int idx);
    case (idx)
      0: return C_RST;
      1: return C_DABT;
      2: return C_FIQ;
      3: return C_IRQ;
      4: return C_PABT;
      5: return C_BKPT;
      6: return C_UND;
      7: return C_SMC;
      default: return C_NONE;
    endcase
  endfunction

  function automatic logic [7:0] vec_offset(cause_e c);
    case (c)
      C_UND:          return 8'h04;
      C_SMC:          return 8'h08;
      C_PABT, C_BKPT: return 8'h0C;
      C_DABT:         return 8'h10;
      C_IRQ:          return 8'h18;
      C_FIQ:          return 8'h1C;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [AW-1:0] link_value(cause_e c, logic [AW-1:0] pc);
    case (c)
      C_RST:   return '0;
      C_DABT:  return pc + AW'(8);
      C_NONE:  return '0;
      default: return pc + AW'(4);
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/exc_router.sv
module exc_router
  import exc_pkg::*;
(
  input  cause_e     cause,
  input  mode_e      cur_mode,
  input  logic       cur_secure,
  input  logic [2:0] route,
  input  logic       dabt_ext,
  input  logic       halt_dbg,
  output cause_e     eff_cause,
  output mode_e      tgt_mode,
  output logic       tgt_secure,
  output logic       take,
  output logic       dbg
);
  always_comb begin
    eff_cause = cause;
    dbg       = 1'b0;
    take      = (cause != C_NONE);
    tgt_mode  = M_SVC;
    if (cause == C_SMC && cur_mode == M_USR) eff_cause = C_UND;
    if (cause == C_BKPT && halt_dbg) begin
      dbg  = 1'b1;
      take = 1'b0;
    end
    case (eff_cause)
      C_RST:          tgt_mode = M_SVC;
      C_DABT:         tgt_mode = (route[2] && dabt_ext) ? M_MON : M_ABT;
      C_FIQ:          tgt_mode = route[1] ? M_MON : M_FIQ;
      C_IRQ:          tgt_mode = route[0] ? M_MON : M_IRQ;
      C_PABT, C_BKPT: tgt_mode = M_ABT;
      C_UND:          tgt_mode = M_UND;
      C_SMC:          tgt_mode = M_MON;
      default:        tgt_mode = M_SVC;
    endcase
    tgt_secure = (tgt_mode == M_MON) || (eff_cause == C_RST) || cur_secure;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter logic [AW-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  cause_e          eff_cause,
  input  mode_e           tgt_mode,
  input  logic            tgt_secure,
  input  logic            hivec,
  input  logic [AW-1:0]   base_ns,
  input  logic [AW-1:0]   base_s,
  input  logic [AW-1:0]   base_mon,
  output logic [AW-1:0]   vec
);
  logic [AW-1:0] base;
  always_comb begin
    if (tgt_mode == M_MON)  base = base_mon;
    else if (hivec)         base = HIVEC_BASE;
    else if (tgt_secure)    base = base_s;
    else                    base = base_ns;
    vec = base + AW'(vec_offset(eff_cause));
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_exc_i,
  input  logic        undef_i,
  input  logic        smc_i,
  input  logic        bkpt_i,
  input  logic        pabt_i,
  input  logic        dabt_i,
  input  logic        dabt_ext_i,
  input  logic        irq_i,
  input  logic        fiq_i,
  input  logic        cur_secure_i,
  input  logic [2:0]  cur_mode_i,
  input  logic        irq_masked_i,
  input  logic        fiq_masked_i,
  input  logic [2:0]  route_i,
  input  logic        hivec_i,
  input  logic [31:0] base_ns_i,
  input  logic [31:0] base_s_i,
  input  logic [31:0] base_mon_i,
  input  logic        halt_dbg_i,
  input  logic        ex_valid_i,
  input  logic [31:0] ex_pc_i,
  output logic        take_o,
  output logic [2:0]  tgt_mode_o,
  output logic        tgt_secure_o,
  output logic [31:0] vec_o,
  output logic [31:0] link_o,
  output logic        set_irq_mask_o,
  output logic        set_fiq_mask_o,
  output logic        dbg_req_o
);
  // eligible requests, index = priority rank
  logic [NREQ-1:0] req_vec, gnt_vec;
  assign req_vec = {smc_i & ex_valid_i, undef_i & ex_valid_i,
                    bkpt_i & ex_valid_i, pabt_i & ex_valid_i,
                    irq_i & ~irq_masked_i, fiq_i & ~fiq_masked_i,
                    dabt_i, rst_exc_i};

  exc_arbiter #(.N(NREQ)) u_arb (.req(req_vec), .gnt(gnt_vec));

  cause_e win_cause;
  always_comb begin
    win_cause = C_NONE;
    for (int i = 0; i < NREQ; i++) begin
      if (gnt_vec[i]) win_cause = slot_cause(i);
    end
  end

  cause_e eff_cause;
  mode_e  tgt_mode;
  logic   tgt_secure, take_d, dbg_d;

  exc_router u_route (
    .cause(win_cause), .cur_mode(mode_e'(cur_mode_i)), .cur_secure(cur_secure_i),
    .route(route_i), .dabt_ext(dabt_ext_i), .halt_dbg(halt_dbg_i),
    .eff_cause(eff_cause), .tgt_mode(tgt_mode), .tgt_secure(tgt_secure),
    .take(take_d), .dbg(dbg_d)
  );

  logic [31:0] vec_d;
  exc_vector #(.HIVEC_BASE(HIVEC_BASE)) u_vec (
    .eff_cause(eff_cause), .tgt_mode(tgt_mode), .tgt_secure(tgt_secure),
    .hivec(hivec_i), .base_ns(base_ns_i), .base_s(base_s_i),
    .base_mon(base_mon_i), .vec(vec_d)
  );

  logic set_fiq_d;
  assign set_fiq_d = take_d && (eff_cause == C_FIQ || tgt_mode == M_MON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o         <= 1'b0;
      tgt_mode_o     <= '0;
      tgt_secure_o   <= 1'b0;
      vec_o          <= '0;
      link_o         <= '0;
      set_irq_mask_o <= 1'b0;
      set_fiq_mask_o <= 1'b0;
      dbg_req_o      <= 1'b0;
    end else begin
      take_o         <= take_d;
      dbg_req_o      <= dbg_d;
      tgt_mode_o     <= take_d ? tgt_mode : 3'd0;
      tgt_secure_o   <= take_d && tgt_secure;
      vec_o          <= take_d ? vec_d : '0;
      link_o         <= take_d ? link_value(eff_cause, ex_pc_i) : '0;
      set_irq_mask_o <= take_d;
      set_fiq_mask_o <= set_fiq_d;
    end
  end

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec));
  a_r2_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(|req_vec));
  a_r6_debug_not_take: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_o |-> !take_o);
  a_r6_debug_source: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_o |-> $past(halt_dbg_i && bkpt_i && ex_valid_i));
  a_r13_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> set_irq_mask_o);
  a_r9_monitor_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && tgt_mode_o == 3'd6) |-> tgt_secure_o);
  a_r10_high_base: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && tgt_mode_o != 3'd6 && $past(hivec_i)) |->
      ((vec_o & ~32'hFF) == (HIVEC_BASE & ~32'hFF)));
  a_r5_squash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid_i && !rst_exc_i && !dabt_i && !(irq_i && !irq_masked_i) &&
     !(fiq_i && !fiq_masked_i)) |=> (!take_o && !dbg_req_o));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_exc_i = 0, undef_i = 0, smc_i = 0, bkpt_i = 0, pabt_i = 0;
  logic dabt_i = 0, dabt_ext_i = 0, irq_i = 0, fiq_i = 0, cur_secure_i = 0;
  logic [2:0] cur_mode_i = 0, route_i = 0;
  logic irq_masked_i = 0, fiq_masked_i = 0, hivec_i = 0, halt_dbg_i = 0, ex_valid_i = 0;
  logic [31:0] base_ns_i = 32'h0000_1000, base_s_i = 32'h0002_0000,
               base_mon_i = 32'h0030_0000, ex_pc_i = 0;
  logic take_o, tgt_secure_o, set_irq_mask_o, set_fiq_mask_o, dbg_req_o;
  logic [2:0] tgt_mode_o;
  logic [31:0] vec_o, link_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected values
  logic e_take, e_dbg, e_sec, e_fm;
  logic [2:0] e_mode;
  logic [31:0] e_vec, e_link;

  task automatic model();
    int w; // 0 none,1 rst,2 dabt,3 fiq,4 irq,5 pabt,6 bkpt,7 und,8 smc
    logic [31:0] base, off;
    w = 0;
    if (rst_exc_i) w = 1;
    else if (dabt_i) w = 2;
    else if (fiq_i && !fiq_masked_i) w = 3;
    else if (irq_i && !irq_masked_i) w = 4;
    else if (ex_valid_i && pabt_i) w = 5;
    else if (ex_valid_i && bkpt_i) w = 6;
    else if (ex_valid_i && undef_i) w = 7;
    else if (ex_valid_i && smc_i) w = 8;
    if (w == 8 && cur_mode_i == 3'd0) w = 7;
    e_dbg = (w == 6) && halt_dbg_i;
    e_take = (w != 0) && !e_dbg;
    e_mode = 0; off = 0; e_link = ex_pc_i + 4;
    case (w)
      1: begin e_mode = 3; off = 0; e_link = 0; end
      2: begin e_mode = (route_i[2] && dabt_ext_i) ? 3'd6 : 3'd4; off = 16; e_link = ex_pc_i + 8; end
      3: begin e_mode = route_i[1] ? 3'd6 : 3'd1; off = 28; end
      4: begin e_mode = route_i[0] ? 3'd6 : 3'd2; off = 24; end
      5, 6: begin e_mode = 4; off = 12; end
      7: begin e_mode = 5; off = 4; end
      8: begin e_mode = 6; off = 8; end
      default: ;
    endcase
    e_sec = (e_mode == 6) || (w == 1) || cur_secure_i;
    if (e_mode == 6) base = base_mon_i;
    else if (hivec_i) base = 32'hFFFF_0000;
    else base = e_sec ? base_s_i : base_ns_i;
    e_vec = base + off;
    e_fm = e_take && (w == 3 || e_mode == 6);
    if (!e_take) begin e_mode = 0; e_sec = 0; e_vec = 0; e_link = 0; end
  endtask

  task automatic step_and_check(input string ctx);
    model();
    @(negedge clk);
    check({"R3/R4/R5 take ", ctx}, 32'(take_o), 32'(e_take));
    check({"R6 dbg ", ctx}, 32'(dbg_req_o), 32'(e_dbg));
    check({"R7/R8 mode ", ctx}, 32'(tgt_mode_o), 32'(e_mode));
    check({"R9 world ", ctx}, 32'(tgt_secure_o), 32'(e_sec));
    check({"R9/R10/R11 vector ", ctx}, vec_o, e_vec);
    check({"R12 link ", ctx}, link_o, e_link);
    check({"R13 irq mask ", ctx}, 32'(set_irq_mask_o), 32'(e_take));
    check({"R13 fiq mask ", ctx}, 32'(set_fiq_mask_o), 32'(e_fm));
  endtask

  task automatic clear_reqs();
    {rst_exc_i, undef_i, smc_i, bkpt_i, pabt_i, dabt_i, dabt_ext_i, irq_i, fiq_i} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset with requests present
    rst_exc_i = 1; irq_i = 1;
    repeat (3) @(negedge clk);
    check("R1 take in reset", 32'(take_o), 0);
    check("R1 vec in reset", vec_o, 0);
    rst_n = 1;
    clear_reqs();
    @(negedge clk);
    check("R1 take after reset", 32'(take_o), 0);
    check("R1 dbg after reset", 32'(dbg_req_o), 0);

    // R7 directed: monitor call from user vs supervisor
    ex_valid_i = 1; smc_i = 1; cur_mode_i = 0; ex_pc_i = 32'h400;
    step_and_check("R7 smc user");
    check("R7 smc user mode", 32'(tgt_mode_o), 5);
    cur_mode_i = 3;
    step_and_check("R7 smc svc");
    check("R7 smc svc vector", vec_o, 32'h0030_0008);
    // R5 directed: squashed breakpoint under halting debug
    clear_reqs(); bkpt_i = 1; ex_valid_i = 0; halt_dbg_i = 1;
    step_and_check("R5 squashed bkpt");
    check("R5 squashed bkpt no dbg", 32'(dbg_req_o), 0);
    // R10 directed: high vectors, non-secure undef and monitor IRQ
    clear_reqs(); ex_valid_i = 1; undef_i = 1; hivec_i = 1; cur_secure_i = 0;
    step_and_check("R10 hivec undef");
    check("R10 hivec undef vector", vec_o, 32'hFFFF_0004);
    clear_reqs(); irq_i = 1; route_i = 3'b001;
    step_and_check("R10 hivec routed irq");
    check("R10 monitor base kept", vec_o, 32'h0030_0018);
    // R2: one-cycle pulse
    clear_reqs();
    step_and_check("R2 idle after pulse");
    check("R2 pulse ended", 32'(take_o), 0);

    // sweep: every request combination against varied configurations
    for (int k = 0; k < 32; k++) begin
      for (int r = 0; r < 512; r++) begin
        int c;
        c = (k * 64) ^ (r * 5) ^ (r >> 3) ^ (k * 7);
        {rst_exc_i, undef_i, smc_i, bkpt_i, pabt_i, dabt_i, dabt_ext_i, irq_i, fiq_i} = 9'(r);
        cur_secure_i = c[0];
        cur_mode_i   = c[1] ? 3'd3 : 3'd0;
        irq_masked_i = c[2];
        fiq_masked_i = c[3];
        route_i      = 3'(c >> 4);
        hivec_i      = c[7];
        halt_dbg_i   = c[8];
        ex_valid_i   = c[9] | c[1];
        ex_pc_i      = 32'h0000_8000 + 32'(r * 4) + 32'(k * 32'h1_0000);
        base_ns_i    = 32'h0000_1000 + 32'(k * 32'h100);
        step_and_check("sweep");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule